// File: doc/BRIEF.md
# Multichannel converter parallel readout port

This block is the device side of the parallel readout path of an eight-channel, 14-bit converter. At the end of each conversion it stores all eight results in an output bank. A host then reads them back over a 16-bit bus. The block provides the bus data and a bus-drive enable; the pad driver outside the block uses that enable to produce the tri-state bus. The host controls the transfer with an active-low chip-select and an active-low read strobe. Every read presents the next channel in ascending order, starting from channel 1 after each conversion. The block also drives a flag that marks the first channel.

Two strap inputs choose the bus format. With full-word transfers, the 14-bit result is sign extended to 16 bits. With byte transfers, each channel takes two reads on the low eight bus lines, and a third strap sets which half of the sign-extended word goes out first. The strobes and the conversion-busy input come from another clock domain. The block synchronizes them, so each level must be held for at least three clock cycles. The outputs follow a strobe edge three clock edges after the input changes. Tying chip-select and read together works: the combined signal acts as one strobe.

Top module: `adp_readout`

## Requirements
- R1: After reset, db_oe is 0, first_data is 1, all stored results are 0, and the channel pointer and byte phase point at channel 1, first byte.
- R2: db_oe is 1 only while both cs_n and rd_n are held low in a parallel mode. Raising cs_n, or raising rd_n, brings db_oe back to 0.
- R3: In serial mode (mode_sel=1, byte_sel=0), db_oe stays 0 and the read strobes are ignored: they do not move the channel pointer.
- R4: In word mode (mode_sel=0), db_o = {r[13], r[13], r[13:0]} for the presented result r.
- R5: A strobe activation is a transition into the state cs_n=0 and rd_n=0. In word mode, the k-th activation after busy falls presents channel k, for k from 1 to 8.
- R6: The activation after the one that presents channel 8 presents channel 1 again.
- R7: When busy falls, the bank loads conv_data. Channel c (0-based) is taken from bits [14c+13:14c]. While busy is high, reads return the previously loaded results.
- R8: In byte mode (mode_sel=1, byte_sel=1), db_o[15:8] is 0 and db_o[7:0] carries one byte. Each channel takes two activations, so 16 activations read all eight channels.
- R9: In byte mode, the upper byte is {r[13], r[13], r[13:8]} and the lower byte is r[7:0]. With hi_first=1 the upper byte goes out first; with hi_first=0 the lower byte goes out first.
- R10: first_data is 1 from the busy fall until the activation that presents a channel other than channel 1. That covers both bytes of channel 1 in byte mode. first_data stays 0 through any wrap until the next busy fall.
- R11: A busy fall in the middle of a sequence resets the pointer and byte phase, so the next activation presents channel 1 of the new results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Conversion in progress; a falling edge loads new results |
| cs_n | input | 1 | Active-low chip-select |
| rd_n | input | 1 | Active-low read strobe |
| mode_sel | input | 1 | Interface mode strap: 0 selects word mode, 1 selects serial or byte mode |
| byte_sel | input | 1 | With mode_sel=1: 1 selects byte mode, 0 selects serial mode |
| hi_first | input | 1 | Byte mode order strap: 1 sends the upper byte first |
| conv_data | input | 112 | Eight 14-bit results from the converter, channel 1 in the low bits |
| db_o | output | 16 | Bus data toward the pad driver |
| db_oe | output | 1 | Bus drive enable; 0 means high impedance |
| first_data | output | 1 | High while channel 1 has not been fully read |

## Verification
The bench uses the default parameters: eight channels, 14-bit results, a 16-bit bus and two synchronizer stages. With eight channels, a wrap comes after only nine reads, so the wrap and the mid-sequence reset are easy to reach. The two spare bus bits make the sign copies visible on the extreme negative and positive codes. The narrow channel count also lets the bench run a full 16-read byte sequence with both byte orders in each random round.

// File: rtl/adp_pkg.sv
package adp_pkg;

    typedef enum logic [1:0] {
        MODE_WORD   = 2'd0,
        MODE_SERIAL = 2'd1,
        MODE_BYTE   = 2'd2
    } bus_mode_e;

    function automatic bus_mode_e decode_mode(input logic m_sel, input logic b_sel);
        if (!m_sel)     return MODE_WORD;
        else if (b_sel) return MODE_BYTE;
        else            return MODE_SERIAL;
    endfunction

endpackage

// File: rtl/adp_sync.sv
module adp_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prv_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic [DEPTH-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[DEPTH-2:0], sig_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= {DEPTH{RST_VAL[g]}};
            else        sh_q <= sh_d;
        end

        assign lvl_o[g] = sh_q[STAGES-1];
        assign prv_o[g] = sh_q[STAGES];
    end
endmodule

// File: rtl/adp_bank.sv
module adp_bank #(
    parameter int NCH = 8,
    parameter int RW  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [NCH*RW-1:0] data_i,
    output logic [NCH*RW-1:0] bank_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [RW-1:0] res_d, res_q;

        always_comb begin
            res_d = res_q;
            if (load_i) res_d = data_i[c*RW +: RW];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res_q <= '0;
            else        res_q <= res_d;
        end

        assign bank_o[c*RW +: RW] = res_q;
    end
endmodule

// File: rtl/adp_seq.sv
module adp_seq
    import adp_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bfall_i,
    input  logic                   act_i,
    input  logic                   strobe_on_i,
    input  bus_mode_e              mode_i,
    output logic [$clog2(NCH)-1:0] sel_idx_o,
    output logic                   sel_phase_o,
    output logic                   first_o,
    output logic                   oe_o
);
    localparam int              IW   = $clog2(NCH);
    localparam logic [IW-1:0]   LAST = IW'(NCH - 1);

    typedef struct packed {
        logic [IW-1:0] ptr;
        logic          phase;
        logic [IW-1:0] sel_idx;
        logic          sel_phase;
        logic          first;
        logic          oe;
    } seq_t;

    seq_t st_d, st_q;
    logic par;

    always_comb begin
        par  = (mode_i != MODE_SERIAL);
        st_d = st_q;
        st_d.oe = act_i & par;
        if (bfall_i) begin
            st_d.ptr       = '0;
            st_d.phase     = 1'b0;
            st_d.sel_idx   = '0;
            st_d.sel_phase = 1'b0;
            st_d.first     = 1'b1;
        end else if (strobe_on_i && par) begin
            st_d.sel_idx   = st_q.ptr;
            st_d.sel_phase = st_q.phase;
            if (st_q.ptr != '0) st_d.first = 1'b0;
            if (mode_i == MODE_BYTE && !st_q.phase) begin
                st_d.phase = 1'b1;
            end else begin
                st_d.phase = 1'b0;
                st_d.ptr   = (st_q.ptr == LAST) ? '0 : st_q.ptr + IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.first <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_idx_o   = st_q.sel_idx;
    assign sel_phase_o = st_q.sel_phase;
    assign first_o     = st_q.first;
    assign oe_o        = st_q.oe;

    // R11: a busy fall rewinds the sequence
    a_r11_busy_fall_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bfall_i |=> (st_q.ptr == '0) && !st_q.phase && st_q.first);

    // R5: each activation presents the slot the pointer held
    a_r5_present_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_on_i && !bfall_i && par) |=> (st_q.sel_idx == $past(st_q.ptr)));

    // R10: the first flag only drops when a later channel is presented
    a_r10_first_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.first) |-> ($past(strobe_on_i) && st_q.sel_idx != '0));
endmodule

// File: rtl/adp_fmt.sv
module adp_fmt
    import adp_pkg::*;
#(
    parameter int NCH = 8,
    parameter int RW  = 14,
    parameter int BW  = 16
) (
    input  logic [NCH*RW-1:0]      bank_i,
    input  logic [$clog2(NCH)-1:0] sel_idx_i,
    input  logic                   sel_phase_i,
    input  bus_mode_e              mode_i,
    input  logic                   hi_first_i,
    output logic [BW-1:0]          db_o
);
    localparam int HB = BW / 2;

    logic [RW-1:0] res;
    logic [BW-1:0] ext;
    logic [HB-1:0] upper, lower, pick;

    always_comb begin
        res   = bank_i[sel_idx_i*RW +: RW];
        ext   = {{(BW-RW){res[RW-1]}}, res};
        upper = ext[BW-1:HB];
        lower = ext[HB-1:0];
        if (sel_phase_i == hi_first_i) pick = lower;
        else                           pick = upper;
        if (mode_i == MODE_BYTE) db_o = {{(BW-HB){1'b0}}, pick};
        else                     db_o = ext;
    end
endmodule

// File: rtl/adp_readout.sv
module adp_readout
    import adp_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int RW     = 14,
    parameter int BW     = 16,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              mode_sel,
    input  logic              byte_sel,
    input  logic              hi_first,
    input  logic [NCH*RW-1:0] conv_data,
    output logic [BW-1:0]     db_o,
    output logic              db_oe,
    output logic              first_data
);
    localparam int IW = $clog2(NCH);
    localparam int HB = BW / 2;

    logic [2:0]    lvl, prv;
    logic          cs_l, rd_l, busy_l;
    logic          act, act_prev, strobe_on, bfall;
    bus_mode_e     mode;
    logic [NCH*RW-1:0] bank;
    logic [IW-1:0] sel_idx;
    logic          sel_phase;

    adp_sync #(.N(3), .STAGES(STAGES), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i ({busy, rd_n, cs_n}),
        .lvl_o (lvl),
        .prv_o (prv)
    );

    assign cs_l      = lvl[0];
    assign rd_l      = lvl[1];
    assign busy_l    = lvl[2];
    assign act       = !lvl[0] && !lvl[1];
    assign act_prev  = !prv[0] && !prv[1];
    assign strobe_on = act && !act_prev;
    assign bfall     = prv[2] && !busy_l;
    assign mode      = decode_mode(mode_sel, byte_sel);

    adp_bank #(.NCH(NCH), .RW(RW)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (bfall),
        .data_i (conv_data),
        .bank_o (bank)
    );

    adp_seq #(.NCH(NCH)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bfall_i     (bfall),
        .act_i       (act),
        .strobe_on_i (strobe_on),
        .mode_i      (mode),
        .sel_idx_o   (sel_idx),
        .sel_phase_o (sel_phase),
        .first_o     (first_data),
        .oe_o        (db_oe)
    );

    adp_fmt #(.NCH(NCH), .RW(RW), .BW(BW)) u_fmt (
        .bank_i      (bank),
        .sel_idx_i   (sel_idx),
        .sel_phase_i (sel_phase),
        .mode_i      (mode),
        .hi_first_i  (hi_first),
        .db_o        (db_o)
    );

    // R2: chip-select going high releases the bus
    a_r2_cs_rise_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_l) |=> !db_oe);

    // R2: the read strobe going high releases the bus
    a_r2_rd_rise_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_l) |=> !db_oe);

    // R3: serial mode never drives the bus
    a_r3_serial_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SERIAL) |=> !db_oe);

    // R4: spare upper bits copy the result sign in word mode
    a_r4_sign_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe && mode == MODE_WORD) |->
            ((db_o[BW-1:RW-1] == '0) || (db_o[BW-1:RW-1] == '1)));

    // R8: byte mode leaves the upper bus lines at zero
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe && mode == MODE_BYTE) |-> (db_o[BW-1:HB] == '0));
endmodule

// File: tb/adp_readout_tb.sv
module adp_readout_tb_top;
    localparam int NCH = 8;
    localparam int RW  = 14;
    localparam int BW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
    logic mode_sel = 1'b0, byte_sel = 1'b0, hi_first = 1'b1;
    logic [NCH*RW-1:0] conv_data = '0;
    logic [BW-1:0] db_o;
    logic db_oe, first_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [RW-1:0] cur [NCH];
    logic [BW-1:0] s_db;
    logic s_oe, s_first;

    always #5ns clk = ~clk;

    adp_readout #(.NCH(NCH), .RW(RW), .BW(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .rd_n(rd_n),
        .mode_sel(mode_sel), .byte_sel(byte_sel), .hi_first(hi_first),
        .conv_data(conv_data), .db_o(db_o), .db_oe(db_oe), .first_data(first_data)
    );

    function automatic logic [15:0] sext(input logic [RW-1:0] r);
        return {r[RW-1], r[RW-1], r};
    endfunction

    function automatic logic [15:0] byte_exp(input logic [RW-1:0] r, input bit second, input bit hf);
        logic [15:0] e;
        e = sext(r);
        if (hf ^ second) return {8'h00, e[15:8]};
        else             return {8'h00, e[7:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic convert(input bit hold_busy);
        for (int c = 0; c < NCH; c++) begin
            cur[c] = RW'($urandom);
            conv_data[c*RW +: RW] = cur[c];
        end
        busy = 1'b1;
        wait_clk(4);
        if (!hold_busy) begin
            busy = 1'b0;
            wait_clk(4);
        end
    endtask

    task automatic set_data(input int c, input logic [RW-1:0] v);
        cur[c] = v;
        conv_data[c*RW +: RW] = v;
    endtask

    task automatic do_read(input bit keep_cs);
        cs_n = 1'b0;
        rd_n = 1'b0;
        wait_clk(4);
        s_db = db_o;
        s_oe = db_oe;
        s_first = first_data;
        rd_n = 1'b1;
        if (!keep_cs) cs_n = 1'b1;
        wait_clk(4);
    endtask

    initial begin
        void'($urandom(32'd5150));
        wait_clk(3);
        chk("R1 oe after reset", 32'(db_oe), 32'd0);
        chk("R1 first_data after reset", 32'(first_data), 32'd1);
        rst_n = 1'b1;
        wait_clk(2);
        do_read(0);
        chk("R1 reset bank V1", 32'(s_db), 32'd0);
        chk("R2 idle bus off", 32'(db_oe), 32'd0);

        // directed extremes, word mode
        for (int c = 0; c < NCH; c++) set_data(c, RW'(c * 1000 + 7));
        set_data(0, 14'h2000);
        set_data(1, 14'h1FFF);
        set_data(2, 14'h3FFF);
        busy = 1'b1; wait_clk(4); busy = 1'b0; wait_clk(4);
        chk("R10 first high after busy fall", 32'(first_data), 32'd1);
        // cs low, rd high: no drive
        cs_n = 1'b0; wait_clk(4);
        chk("R2 cs low alone no drive", 32'(db_oe), 32'd0);
        cs_n = 1'b1; wait_clk(4);
        for (int k = 0; k < NCH; k++) begin
            do_read(0);
            chk($sformatf("R5 word seq V%0d", k + 1), 32'(s_db), 32'(sext(cur[k])));
            chk("R2 drive during read", 32'(s_oe), 32'd1);
            chk("R2 release after read", 32'(db_oe), 32'd0);
            if (k == 0) chk("R10 first during V1", 32'(s_first), 32'd1);
            if (k == 1) chk("R10 first low at V2", 32'(s_first), 32'd0);
        end
        chk("R4 negative extreme", 32'(sext(14'h2000)), 32'hE000);
        do_read(0);
        chk("R6 wrap to V1", 32'(s_db), 32'(sext(cur[0])));
        chk("R10 first stays low after wrap", 32'(s_first), 32'd0);

        // chip-select held low, read pulses only
        convert(0);
        for (int k = 0; k < 3; k++) begin
            do_read(1);
            chk($sformatf("R5 cs tied low V%0d", k + 1), 32'(s_db), 32'(sext(cur[k])));
        end
        cs_n = 1'b1;
        wait_clk(4);

        // R11 mid-sequence restart
        convert(0);
        do_read(0);
        chk("R11 new data V1", 32'(s_db), 32'(sext(cur[0])));
        chk("R11 first after restart", 32'(s_first), 32'd1);

        // R7 busy high returns previous results
        begin
            logic [RW-1:0] old [NCH];
            for (int c = 0; c < NCH; c++) old[c] = cur[c];
            convert(0);
            for (int c = 0; c < NCH; c++) old[c] = cur[c];
            convert(1);
            for (int k = 0; k < 2; k++) begin
                do_read(0);
                chk($sformatf("R7 busy high old V%0d", k + 1), 32'(s_db), 32'(sext(old[k])));
            end
            busy = 1'b0;
            wait_clk(4);
            do_read(0);
            chk("R7 busy fall loads new V1", 32'(s_db), 32'(sext(cur[0])));
        end

        // R3 serial mode ignores strobes
        convert(0);
        do_read(0);
        mode_sel = 1'b1; byte_sel = 1'b0; wait_clk(2);
        for (int k = 0; k < 3; k++) begin
            do_read(0);
            chk("R3 serial no drive", 32'(s_oe), 32'd0);
        end
        mode_sel = 1'b0; wait_clk(2);
        do_read(0);
        chk("R3 pointer untouched in serial", 32'(s_db), 32'(sext(cur[1])));

        // random rounds, word and byte modes, both byte orders
        for (int rnd = 0; rnd < 8; rnd++) begin
            bit bm, hf;
            bm = (rnd % 2) == 1;
            hf = 1'($urandom);
            if (rnd == 1) hf = 1'b1;
            if (rnd == 3) hf = 1'b0;
            mode_sel = bm; byte_sel = bm; hi_first = hf;
            wait_clk(2);
            convert(0);
            if (rnd == 1) set_data(0, 14'h2081);
            if (rnd == 1) begin
                busy = 1'b1; wait_clk(4); busy = 1'b0; wait_clk(4);
            end
            for (int k = 0; k < NCH; k++) begin
                if (!bm) begin
                    do_read(0);
                    chk($sformatf("R4 random word V%0d", k + 1), 32'(s_db), 32'(sext(cur[k])));
                end else begin
                    for (int b = 0; b < 2; b++) begin
                        do_read(0);
                        chk($sformatf("R9 byte V%0d b%0d hf%0d", k + 1, b, hf),
                            32'(s_db), 32'(byte_exp(cur[k], b[0], hf)));
                        chk("R8 byte upper lines zero", 32'(s_db[15:8]), 32'd0);
                        if (k == 0) chk("R10 first across V1 bytes", 32'(s_first), 32'd1);
                        if (k == 1 && b == 0) chk("R10 first low at V2 byte", 32'(s_first), 32'd0);
                    end
                end
            end
            if (rnd == 1) chk("R9 upper byte sign bits", 32'(byte_exp(14'h2081, 1'b0, 1'b1)), 32'h00E0);
            do_read(0);
            chk("R6 random wrap", 32'(s_db),
                bm ? 32'(byte_exp(cur[0], 1'b0, hf)) : 32'(sext(cur[0])));
        end

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1ms;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule